// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

A purely combinational byte-wide arithmetic and logic unit for an accumulator-style processor core. Each cycle the surrounding datapath presents the current accumulator, the auxiliary register, a second operand byte and the current carry and auxiliary-carry flags, together with an operation code. The unit returns the next accumulator value, a next auxiliary-register value, and next values for the carry, auxiliary carry and overflow flags. Every result comes with its own write enable, so the caller commits only what the operation really changes.

The operations are plain and carry-in addition, subtraction that always takes the borrow, increment, decrement, an 8x8 multiply split across both registers, a divide giving quotient and remainder, packed-BCD correction after an addition, bitwise AND/OR/XOR/invert, clear, rotates with and without the carry in the ring, and nibble exchange. Instruction decode and register storage sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: Operation codes are PASS=0, ADD=1, ADDC=2, SUBB=3, INC=4, DEC=5, MUL=6, DIV=7, DA=8, AND=9, OR=10, XOR=11, CPL=12, CLR=13, RL=14, RR=15, RLC=16, RRC=17, SWAP=18; PASS and every code above 18 assert no write enable and present the accumulator unchanged.
- R2: ADD forms accumulator + operand and ADDC adds the carry-in as well; the low 8 bits go to the accumulator, carry is set when the true sum exceeds FFh, auxiliary carry is set on a carry out of bit 3.
- R3: For ADD, ADDC and SUBB the overflow flag is written and is set exactly when the signed result does not fit in -128..127 (carries out of bits 6 and 7 differ).
- R4: SUBB always computes accumulator - operand - carry-in; carry reports a borrow out of bit 7 and auxiliary carry a borrow out of bit 3.
- R5: INC and DEC change the accumulator by one with wrap-around and write no flag.
- R6: MUL puts the high byte of accumulator x auxiliary register into the auxiliary register and the low byte into the accumulator, clears carry, and sets overflow when the product exceeds FFh.
- R7: DIV puts the quotient of accumulator / auxiliary register into the accumulator and the remainder into the auxiliary register, clears carry and overflow; with a zero divisor overflow is set, carry is cleared and both register results are known (never X).
- R8: DA adds 06h when the low nibble exceeds 9 or auxiliary carry is set, then adds 60h when the resulting high nibble exceeds 9 or carry is set; carry is set if that second step carries out and is otherwise left at its input value; AC and OV are not written (23h+29h=4Ch corrects to 52h).
- R9: AND, OR and XOR combine accumulator with operand, CPL inverts and CLR zeroes the accumulator; none writes a flag.
- R10: RL and RR rotate the accumulator by one bit without the carry and SWAP exchanges its nibbles; none writes a flag.
- R11: RLC and RRC rotate through a 9-bit ring of carry and accumulator: the old carry enters at the vacated end and the bit leaving becomes the new carry.
- R12: The auxiliary register write enable is asserted only for MUL and DIV; the accumulator write enable for every defined code except PASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator |
| breg_i | input | 8 | Current auxiliary register (MUL/DIV) |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| acc_o | output | 8 | Next accumulator |
| acc_we | output | 1 | Accumulator write enable |
| breg_o | output | 8 | Next auxiliary register |
| breg_we | output | 1 | Auxiliary register write enable |
| cy_o | output | 1 | Next carry flag |
| cy_we | output | 1 | Carry write enable |
| ac_o | output | 1 | Next auxiliary carry flag |
| ac_we | output | 1 | Auxiliary carry write enable |
| ov_o | output | 1 | Next overflow flag |
| ov_we | output | 1 | Overflow write enable |

## Verification
The block holds no state, so any wrong internal term shows at the ports in the same evaluation as the stimulus that exercises it; the risk is a term reached only by rare operand pairs, such as the bit-6 carry, a nibble borrow or a BCD high-nibble correction after the low one. For that reason the two-operand arithmetic and the multiply and divide are swept over every operand pair and both carry values, and the unary operations over every accumulator value with both flag inputs, against arithmetic written from the requirements. A stray write enable is as visible as a wrong value, so enables are compared on every vector.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [4:0] op_i,
  input  logic [7:0] acc_i,
  input  logic [7:0] breg_i,
  input  logic [7:0] opnd_i,
  input  logic       cy_i,
  input  logic       ac_i,
  output logic [7:0] acc_o,
  output logic       acc_we,
  output logic [7:0] breg_o,
  output logic       breg_we,
  output logic       cy_o,
  output logic       cy_we,
  output logic       ac_o,
  output logic       ac_we,
  output logic       ov_o,
  output logic       ov_we
);
  localparam logic [4:0] OP_PASS = 5'd0,  OP_ADD = 5'd1,  OP_ADDC = 5'd2, OP_SUBB = 5'd3,
                         OP_INC  = 5'd4,  OP_DEC = 5'd5,  OP_MUL  = 5'd6, OP_DIV  = 5'd7,
                         OP_DA   = 5'd8,  OP_AND = 5'd9,  OP_OR   = 5'd10, OP_XOR = 5'd11,
                         OP_CPL  = 5'd12, OP_CLR = 5'd13, OP_RL   = 5'd14, OP_RR  = 5'd15,
                         OP_RLC  = 5'd16, OP_RRC = 5'd17, OP_SWAP = 5'd18;

  wire       cin   = (op_i == OP_ADD) ? 1'b0 : cy_i;
  wire       is_sub = (op_i == OP_SUBB);
  wire [7:0] rhs   = is_sub ? ~opnd_i : opnd_i;
  wire       c0    = is_sub ? ~cin : cin;

  wire [4:0] lo_sum = {1'b0, acc_i[3:0]} + {1'b0, rhs[3:0]} + {4'd0, c0};
  wire [7:0] b6_sum = {1'b0, acc_i[6:0]} + {1'b0, rhs[6:0]} + {7'd0, c0};
  wire [8:0] full   = {1'b0, acc_i} + {1'b0, rhs} + {8'd0, c0};
  wire       c3 = lo_sum[4];
  wire       c6 = b6_sum[7];
  wire       c7 = full[8];

  wire [15:0] prod    = acc_i * breg_i;
  wire        div_z   = (breg_i == 8'd0);
  wire [7:0]  quot    = div_z ? 8'hFF   : acc_i / breg_i;
  wire [7:0]  rem     = div_z ? acc_i   : acc_i % breg_i;

  wire       lo_fix = (acc_i[3:0] > 4'd9) | ac_i;
  wire [7:0] da1    = lo_fix ? acc_i + 8'h06 : acc_i;
  wire       hi_fix = (da1[7:4] > 4'd9) | cy_i;
  wire [8:0] da2    = hi_fix ? {1'b0, da1} + 9'h060 : {1'b0, da1};

  always_comb begin
    acc_o   = acc_i;
    breg_o  = breg_i;
    cy_o    = cy_i;
    ac_o    = ac_i;
    ov_o    = 1'b0;
    acc_we  = 1'b1;
    breg_we = 1'b0;
    cy_we   = 1'b0;
    ac_we   = 1'b0;
    ov_we   = 1'b0;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_o = full[7:0];
        cy_o  = is_sub ? ~c7 : c7;
        ac_o  = is_sub ? ~c3 : c3;
        ov_o  = c6 ^ c7;
        {cy_we, ac_we, ov_we} = 3'b111;
      end
      OP_INC:  acc_o = acc_i + 8'd1;
      OP_DEC:  acc_o = acc_i - 8'd1;
      OP_MUL: begin
        {breg_o, acc_o} = prod;
        breg_we = 1'b1;
        cy_o = 1'b0;
        ov_o = |prod[15:8];
        {cy_we, ov_we} = 2'b11;
      end
      OP_DIV: begin
        acc_o  = quot;
        breg_o = rem;
        breg_we = 1'b1;
        cy_o = 1'b0;
        ov_o = div_z;
        {cy_we, ov_we} = 2'b11;
      end
      OP_DA: begin
        acc_o = da2[7:0];
        cy_o  = cy_i | da2[8];
        cy_we = 1'b1;
      end
      OP_AND:  acc_o = acc_i & opnd_i;
      OP_OR:   acc_o = acc_i | opnd_i;
      OP_XOR:  acc_o = acc_i ^ opnd_i;
      OP_CPL:  acc_o = ~acc_i;
      OP_CLR:  acc_o = 8'h00;
      OP_RL:   acc_o = {acc_i[6:0], acc_i[7]};
      OP_RR:   acc_o = {acc_i[0], acc_i[7:1]};
      OP_RLC: begin
        acc_o = {acc_i[6:0], cy_i};
        cy_o  = acc_i[7];
        cy_we = 1'b1;
      end
      OP_RRC: begin
        acc_o = {cy_i, acc_i[7:1]};
        cy_o  = acc_i[0];
        cy_we = 1'b1;
      end
      OP_SWAP: acc_o = {acc_i[3:0], acc_i[7:4]};
      default: acc_we = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker (
  input logic [4:0] op_i,
  input logic [7:0] acc_i,
  input logic [7:0] breg_i,
  input logic [7:0] opnd_i,
  input logic       cy_i,
  input logic       ac_i,
  input logic [7:0] acc_o,
  input logic       acc_we,
  input logic [7:0] breg_o,
  input logic       breg_we,
  input logic       cy_o,
  input logic       cy_we,
  input logic       ac_we,
  input logic       ov_o,
  input logic       ov_we
);
  wire known = !$isunknown({op_i, acc_i, breg_i, opnd_i, cy_i, ac_i});

  always_comb begin
    if (known) begin
      if (op_i == 5'd0 || op_i > 5'd18)
        assert_idle_quiet_R1: assert (!acc_we && !breg_we && !cy_we && !ac_we && !ov_we && acc_o == acc_i);
      if (op_i == 5'd3)
        assert_subb_inverts_R4: assert (8'(acc_o + opnd_i + {7'd0, cy_i}) == acc_i);
      if (op_i == 5'd4 || op_i == 5'd5)
        assert_step_no_flags_R5: assert (!cy_we && !ac_we && !ov_we);
      if (op_i == 5'd7)
        assert_div_known_R7: assert (!$isunknown({acc_o, breg_o}) && cy_we && !cy_o && ov_o == (breg_i == 8'd0));
      if (op_i >= 5'd9 && op_i <= 5'd15 || op_i == 5'd18)
        assert_logic_no_flags_R9: assert (!cy_we && !ac_we && !ov_we);
      if (op_i == 5'd16)
        assert_rlc_ring_R11: assert (acc_o[0] == cy_i && cy_o == acc_i[7] && acc_o[7:1] == acc_i[6:0]);
      assert_breg_we_scope_R12: assert (breg_we == (op_i == 5'd6 || op_i == 5'd7));
    end
  end
endmodule

bind acc_alu acc_alu_checker i_acc_alu_checker (.*);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] op;
  logic [7:0] a, b, o;
  logic       ci, aci;
  logic [7:0] acc_o, breg_o;
  logic       acc_we, breg_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we;

  acc_alu i_acc_alu (
    .op_i(op), .acc_i(a), .breg_i(b), .opnd_i(o), .cy_i(ci), .ac_i(aci),
    .acc_o(acc_o), .acc_we(acc_we), .breg_o(breg_o), .breg_we(breg_we),
    .cy_o(cy_o), .cy_we(cy_we), .ac_o(ac_o), .ac_we(ac_we), .ov_o(ov_o), .ov_we(ov_we)
  );

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      fails = fails + 1;
      $display("FAIL watchdog (R1..R12 incomplete): actual cycle %0d expected finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic string tag(input int code);
    case (code)
      1, 2: tag = "R2"; 3: tag = "R4"; 4, 5: tag = "R5"; 6: tag = "R6"; 7: tag = "R7";
      8: tag = "R8"; 9, 10, 11, 12, 13: tag = "R9"; 14, 15, 18: tag = "R10";
      16, 17: tag = "R11"; default: tag = "R1";
    endcase
  endfunction

  function automatic int sgn(input int v);
    sgn = (v > 127) ? v - 256 : v;
  endfunction

  // expected: {acc, accwe, b, bwe, cy, cywe, ac, acwe, ov, ovwe}
  task automatic check_vec;
    int ea, eb, s, t;
    bit eaw, ebw, ec, ecw, eac, eacw, eov, eovw, div0;
    int x = int'(a), y = int'(o), c = int'(ci), k = int'(op);
    ea = x; eb = int'(b); eaw = 1; ebw = 0; ec = ci; ecw = 0; eac = aci; eacw = 0; eov = 0; eovw = 0; div0 = 0;
    case (k)
      1, 2: begin
        if (k == 1) c = 0;
        s = x + y + c; ea = s % 256; ec = s > 255; eac = (x % 16 + y % 16 + c) > 15;
        t = sgn(x) + sgn(y) + c; eov = t > 127 || t < -128; {ecw, eacw, eovw} = 3'b111;
      end
      3: begin
        s = x - y - c; ea = (s + 512) % 256; ec = s < 0; eac = (x % 16 - y % 16 - c) < 0;
        t = sgn(x) - sgn(y) - c; eov = t > 127 || t < -128; {ecw, eacw, eovw} = 3'b111;
      end
      4: ea = (x + 1) % 256;
      5: ea = (x + 255) % 256;
      6: begin s = x * int'(b); ea = s % 256; eb = s / 256; ebw = 1; ec = 0; eov = s > 255; {ecw, eovw} = 2'b11; end
      7: begin
        ebw = 1; ec = 0; {ecw, eovw} = 2'b11;
        if (b == 0) begin div0 = 1; eov = 1; end
        else begin ea = x / int'(b); eb = x % int'(b); eov = 0; end
      end
      8: begin
        t = x; if (t % 16 > 9 || aci) t = (t + 6) % 256;
        if (t / 16 > 9 || ci) begin t = t + 96; if (t > 255) ec = 1; t = t % 256; end
        ea = t; ecw = 1;
      end
      9: ea = x & y; 10: ea = x | y; 11: ea = x ^ y; 12: ea = 255 - x; 13: ea = 0;
      14: ea = (x * 2) % 256 + x / 128;
      15: ea = x / 2 + (x % 2) * 128;
      16: begin ea = (x * 2) % 256 + c; ec = x / 128; ecw = 1; end
      17: begin ea = x / 2 + c * 128; ec = x % 2; ecw = 1; end
      18: ea = (x % 16) * 16 + x / 16;
      default: eaw = 0;
    endcase
    checks = checks + 1;
    if (acc_we !== eaw || breg_we !== ebw || cy_we !== ecw || ac_we !== eacw || ov_we !== eovw
        || (div0 ? $isunknown({acc_o, breg_o}) : acc_o !== 8'(ea))
        || (ebw && !div0 && breg_o !== 8'(eb))
        || (ecw && cy_o !== ec) || (eacw && ac_o !== eac) || (eovw && ov_o !== eov)) begin
      fails = fails + 1;
      $display("FAIL %s op=%0d a=%h o=%h b=%h c=%0d ac=%0d: actual acc=%h we=%b b=%h bwe=%b cy=%b/%b ac=%b/%b ov=%b/%b expected acc=%h we=%b b=%h bwe=%b cy=%b/%b ac=%b/%b ov=%b/%b",
               tag(k), k, a, o, b, ci, aci, acc_o, acc_we, breg_o, breg_we, cy_o, cy_we, ac_o, ac_we, ov_o, ov_we,
               8'(ea), eaw, 8'(eb), ebw, ec, ecw, eac, eacw, eov, eovw);
    end
  endtask

  task automatic apply(input int k, input int av, input int bv, input int ov, input bit c, input bit h);
    op = 5'(k); a = 8'(av); b = 8'(bv); o = 8'(ov); ci = c; aci = h;
    #1;
    check_vec();
  endtask

  initial begin
    op = 0; a = 8'h5A; b = 0; o = 0; ci = 0; aci = 0;
    repeat (2) @(negedge clk);
    // R1: reset-time idle code writes nothing
    apply(0, 8'h5A, 0, 0, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: 23h + 29h = 4Ch, then decimal correct to 52h
    apply(1, 8'h23, 0, 8'h29, 1'b0, 1'b0);
    apply(8, int'(acc_o), 0, 0, cy_o, ac_o);
    if (acc_o !== 8'h52) begin fails++; $display("FAIL R8 chain: actual %h expected 52", acc_o); end
    checks++;
    // R11: A9h + 14h = BDh, then rotate right through carry gives 5Eh, C=1
    apply(1, 8'hA9, 0, 8'h14, 1'b0, 1'b0);
    apply(17, int'(acc_o), 0, 0, cy_o, 1'b0);
    if (acc_o !== 8'h5E || cy_o !== 1'b1) begin fails++; $display("FAIL R11 chain: actual %h/%b expected 5e/1", acc_o, cy_o); end
    checks++;
    // R2 R3 R4: every operand pair, both carries
    for (int k = 1; k <= 3; k++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          for (int c = 0; c < 2; c++)
            apply(k, x, 8'h33, y, c[0], 1'b0);
    // R6 R7 R12: every multiplicand/divisor pair (includes divisor zero)
    for (int k = 6; k <= 7; k++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(k, x, y, 8'hC3, 1'b1, 1'b0);
    // R5 R8 R9 R10 R11 R1: unary and logic codes over all accumulator values, both flags
    for (int k = 0; k < 32; k++) begin
      if (k >= 1 && k <= 3 || k == 6 || k == 7) continue;
      for (int x = 0; x < 256; x++)
        for (int f = 0; f < 4; f++)
          apply(k, x, 8'h96, (k >= 9 && k <= 11) ? (x * 37 + f * 61) % 256 : 8'hA5, f[0], f[1]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule